// File: doc/BRIEF.md
# Indexed Bus Master Access Unit

This unit carries out the memory-bus loads and stores of a small accumulator processor. When the sequencer sends a start pulse, the unit captures five things: the transfer direction, a lane-selection mode with its selector, the 32-bit index register, a 32-bit instruction operand and the accumulator.

The unit adds the low 28 bits of the operand to the index to form the bus address. It derives the byte enables from the selected mode, then drives a single read or write on a 32-bit memory-mapped master port. It holds that request until the slave stops stalling.

A read waits for the returned data word, which becomes the new accumulator value together with fresh zero and negative flags. A write sends the captured accumulator as write data. Either way, a one-cycle done pulse tells the sequencer that the operation has finished. The unit ignores further start pulses until it returns to idle.

Top module: `ixbus_access`

## Requirements
- R1: The bus address is `index_i` plus the zero-extended `operand_i[27:0]`, modulo 2^32. Operand bits 31..28 never affect the address.
- R2: With `lane_mode_i` = 0 (raw), `avm_byteenable_o` equals `operand_i[31:28]`. Enable bit i selects data bits 8i+7..8i.
- R3: With `lane_mode_i` = 1 (byte), exactly one enable bit is set: bit number `lane_sel_i`.
- R4: With `lane_mode_i` = 2 (half), `lane_sel_i[0]` = 0 gives enables 4'b0011 and `lane_sel_i[0]` = 1 gives 4'b1100. `lane_sel_i[1]` is ignored.
- R5: With `lane_mode_i` = 3 (word), the byte enables are 4'b1111.
- R6: A read loads `avm_readdata_i` into `acc_o`, with `zero_o` = (data == 0) and `neg_o` = data bit 31. A write leaves `acc_o`, `zero_o` and `neg_o` unchanged.
- R7: A write drives on `avm_writedata_o` the value `acc_i` had in the start cycle, even if `acc_i` changes afterwards.
- R8: While `avm_waitrequest_i` is high, the unit keeps the active read or write strobe asserted and holds address, byte enables and write data stable. The request is accepted in the first cycle with waitrequest low.
- R9: Call the cycle in which start is sampled cycle 1. The strobe is first high in cycle 3. With no wait states and read data returned in the cycle after acceptance, done is high in cycle 5. Each wait state adds one cycle, and so does each cycle of extra read-data delay.
- R10: `done_o` is high for exactly one cycle. For a read, that cycle directly follows the cycle in which `avm_readdatavalid_i` was high.
- R11: A start pulse that arrives while the unit is busy, including in the done cycle, is ignored. It issues no bus request and causes no extra done pulse.
- R12: After reset, both strobes and `done_o` are low, `acc_o` is 0, `zero_o` is 1 and `neg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; sampled only when idle |
| is_write_i | input | 1 | 1 = write, 0 = read |
| lane_mode_i | input | 2 | 0 raw, 1 byte, 2 half-word, 3 word |
| lane_sel_i | input | 2 | Byte lane (byte mode) or half select in bit 0 (half mode) |
| index_i | input | 32 | Index register |
| operand_i | input | 32 | Instruction operand: [27:0] offset, [31:28] raw enables |
| acc_i | input | 32 | Accumulator, used as write data |
| done_o | output | 1 | One-cycle completion pulse |
| acc_o | output | 32 | Accumulator value from the last read |
| zero_o | output | 1 | Last read data was zero |
| neg_o | output | 1 | Bit 31 of the last read data |
| avm_address_o | output | 32 | Bus byte address |
| avm_byteenable_o | output | 4 | Bus byte enables |
| avm_read_o | output | 1 | Read strobe |
| avm_write_o | output | 1 | Write strobe |
| avm_writedata_o | output | 32 | Write data |
| avm_waitrequest_i | input | 1 | Slave stall |
| avm_readdata_i | input | 32 | Read data |
| avm_readdatavalid_i | input | 1 | Read data valid |

## Verification
The bench makes the slave stall, holds back read data and changes every input during busy cycles. A unit that sampled `acc_i` late would write the wrong data. One that accepted starts while busy would issue a spurious transfer or a second done. One that let the request drift during a stall would present a different address or enables on the accepted cycle.

An index near 2^32 checks that the address wraps correctly, and operand top nibbles of 0xF check that those bits do not leak into the sum. Byte lanes, both half-word selects (one with the unused selector bit set), raw nibbles of 0 and 0xA, and read data of zero and negative values cover the enable decoding and flag logic. Cycle counting from start to done catches a missing or extra pipeline stage.

// File: rtl/ixbus_pkg.sv
package ixbus_pkg;

    // Lane selection modes; encoding is part of the port contract.
    typedef enum logic [1:0] {
        LANE_RAW  = 2'd0,
        LANE_BYTE = 2'd1,
        LANE_HALF = 2'd2,
        LANE_WORD = 2'd3
    } lane_mode_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ADDR = 3'd1,
        S_REQ  = 3'd2,
        S_RESP = 3'd3,
        S_ACK  = 3'd4,
        S_FIN  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/ixbus_lane_gen.sv
module ixbus_lane_gen
    import ixbus_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8,
    localparam int SEL_W = (BE_W > 2) ? $clog2(BE_W) : 1
) (
    input  lane_mode_e        mode_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic [BE_W-1:0]   be_o
);

    // One enable bit per byte lane.
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        logic half_hit;
        if (g >= BE_W / 2) begin : g_upper
            assign half_hit = sel_i[0];
        end else begin : g_lower
            assign half_hit = ~sel_i[0];
        end

        assign be_o[g] = (mode_i == LANE_RAW)  ? operand_i[DATA_W-BE_W+g] :
                         (mode_i == LANE_BYTE) ? (sel_i == SEL_W'(g)) :
                         (mode_i == LANE_HALF) ? half_hit :
                                                 1'b1;
    end

endmodule

// File: rtl/ixbus_addr_calc.sv
module ixbus_addr_calc #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 28
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFFS_W-1:0] offs_i,
    output logic [ADDR_W-1:0] sum_o
);

    // Offset is unsigned; carry out of the top bit is dropped (wraps).
    assign sum_o = base_i + ADDR_W'(offs_i);

endmodule

// File: rtl/ixbus_seq.sv
module ixbus_seq
    import ixbus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 28,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wr_i,
    input  lane_mode_e        mode_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic [ADDR_W-1:0] index_i,
    input  logic [OFFS_W-1:0] offs_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [ADDR_W-1:0] sum_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [OFFS_W-1:0] offs_o,
    output logic [ADDR_W-1:0] avm_address_o,
    output logic [BE_W-1:0]   avm_byteenable_o,
    output logic              avm_read_o,
    output logic              avm_write_o,
    output logic [DATA_W-1:0] avm_writedata_o,
    input  logic              avm_waitrequest_i,
    input  logic [DATA_W-1:0] avm_readdata_i,
    input  logic              avm_readdatavalid_i,
    output logic              done_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              zero_o,
    output logic              neg_o
);

    typedef struct packed {
        seq_state_e        st;
        logic              wr;
        lane_mode_e        mode;
        logic [BE_W-1:0]   be;
        logic [ADDR_W-1:0] addr;
        logic [OFFS_W-1:0] offs;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] acc;
        logic              zero;
        logic              neg;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.st    = S_ADDR;
                    d.wr    = wr_i;
                    d.mode  = mode_i;
                    d.be    = be_i;
                    d.addr  = index_i;
                    d.offs  = offs_i;
                    d.wdata = acc_i;
                end
            end
            S_ADDR: begin
                d.addr = sum_i;
                d.st   = S_REQ;
            end
            S_REQ: begin
                if (!avm_waitrequest_i) begin
                    d.st = q.wr ? S_ACK : S_RESP;
                end
            end
            S_RESP: begin
                if (avm_readdatavalid_i) begin
                    d.acc  = avm_readdata_i;
                    d.zero = (avm_readdata_i == '0);
                    d.neg  = avm_readdata_i[DATA_W-1];
                    d.st   = S_FIN;
                end
            end
            S_ACK:   d.st = S_FIN;
            S_FIN:   d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.mode  <= LANE_WORD;
            q.zero  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign base_o           = q.addr;
    assign offs_o           = q.offs;
    assign avm_address_o    = q.addr;
    assign avm_byteenable_o = q.be;
    assign avm_writedata_o  = q.wdata;
    assign avm_read_o       = (q.st == S_REQ) && !q.wr;
    assign avm_write_o      = (q.st == S_REQ) && q.wr;
    assign done_o           = (q.st == S_FIN);
    assign acc_o            = q.acc;
    assign zero_o           = q.zero;
    assign neg_o            = q.neg;

    // Stalled request keeps its strobe and every qualifier.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((avm_read_o || avm_write_o) && avm_waitrequest_i) |=>
        ((avm_read_o || avm_write_o) && $stable(avm_address_o) &&
         $stable(avm_byteenable_o) && $stable(avm_writedata_o)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == S_RESP) && avm_readdatavalid_i) |=>
        (done_o && (acc_o == $past(avm_readdata_i))));

    assert_strobe_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avm_read_o || avm_write_o) |-> ($past(q.st) == S_ADDR));

    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st != S_IDLE) && start_i) |=> ($stable(q.offs) && $stable(q.wdata)));

    assert_byte_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((avm_read_o || avm_write_o) && (q.mode == LANE_BYTE)) |->
        $onehot0(avm_byteenable_o) && (avm_byteenable_o != '0));

    assert_half_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((avm_read_o || avm_write_o) && (q.mode == LANE_HALF)) |->
        ($countones(avm_byteenable_o) == BE_W / 2));

endmodule

// File: rtl/ixbus_access.sv
module ixbus_access
    import ixbus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 28,
    localparam int BE_W  = DATA_W / 8,
    localparam int SEL_W = (BE_W > 2) ? $clog2(BE_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_write_i,
    input  logic [1:0]        lane_mode_i,
    input  logic [SEL_W-1:0]  lane_sel_i,
    input  logic [ADDR_W-1:0] index_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] acc_i,
    output logic              done_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              zero_o,
    output logic              neg_o,
    output logic [ADDR_W-1:0] avm_address_o,
    output logic [BE_W-1:0]   avm_byteenable_o,
    output logic              avm_read_o,
    output logic              avm_write_o,
    output logic [DATA_W-1:0] avm_writedata_o,
    input  logic              avm_waitrequest_i,
    input  logic [DATA_W-1:0] avm_readdata_i,
    input  logic              avm_readdatavalid_i
);

    lane_mode_e        mode;
    logic [BE_W-1:0]   be_calc;
    logic [ADDR_W-1:0] base;
    logic [OFFS_W-1:0] offs;
    logic [ADDR_W-1:0] sum;

    assign mode = lane_mode_e'(lane_mode_i);

    ixbus_lane_gen #(.DATA_W(DATA_W)) u_lane (
        .mode_i    (mode),
        .sel_i     (lane_sel_i),
        .operand_i (operand_i),
        .be_o      (be_calc)
    );

    ixbus_addr_calc #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_addr (
        .base_i (base),
        .offs_i (offs),
        .sum_o  (sum)
    );

    ixbus_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_seq (
        .clk                 (clk),
        .rst_n               (rst_n),
        .start_i             (start_i),
        .wr_i                (is_write_i),
        .mode_i              (mode),
        .be_i                (be_calc),
        .index_i             (index_i),
        .offs_i              (operand_i[OFFS_W-1:0]),
        .acc_i               (acc_i),
        .sum_i               (sum),
        .base_o              (base),
        .offs_o              (offs),
        .avm_address_o       (avm_address_o),
        .avm_byteenable_o    (avm_byteenable_o),
        .avm_read_o          (avm_read_o),
        .avm_write_o         (avm_write_o),
        .avm_writedata_o     (avm_writedata_o),
        .avm_waitrequest_i   (avm_waitrequest_i),
        .avm_readdata_i      (avm_readdata_i),
        .avm_readdatavalid_i (avm_readdatavalid_i),
        .done_o              (done_o),
        .acc_o               (acc_o),
        .zero_o              (zero_o),
        .neg_o               (neg_o)
    );

endmodule

// File: tb/ixbus_access_tb.sv
module ixbus_access_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        is_write_i = 1'b0;
    logic [1:0]  lane_mode_i = 2'd0;
    logic [1:0]  lane_sel_i = 2'd0;
    logic [31:0] index_i = '0;
    logic [31:0] operand_i = '0;
    logic [31:0] acc_i = '0;
    logic        done_o;
    logic [31:0] acc_o;
    logic        zero_o;
    logic        neg_o;
    logic [31:0] avm_address_o;
    logic [3:0]  avm_byteenable_o;
    logic        avm_read_o;
    logic        avm_write_o;
    logic [31:0] avm_writedata_o;
    logic        avm_waitrequest_i = 1'b0;
    logic [31:0] avm_readdata_i = '0;
    logic        avm_readdatavalid_i = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ixbus_access u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_write_i(is_write_i),
        .lane_mode_i(lane_mode_i), .lane_sel_i(lane_sel_i), .index_i(index_i),
        .operand_i(operand_i), .acc_i(acc_i), .done_o(done_o), .acc_o(acc_o),
        .zero_o(zero_o), .neg_o(neg_o), .avm_address_o(avm_address_o),
        .avm_byteenable_o(avm_byteenable_o), .avm_read_o(avm_read_o),
        .avm_write_o(avm_write_o), .avm_writedata_o(avm_writedata_o),
        .avm_waitrequest_i(avm_waitrequest_i), .avm_readdata_i(avm_readdata_i),
        .avm_readdatavalid_i(avm_readdatavalid_i)
    );

    typedef struct {
        logic        wr;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] rdata;
        int          waits;
        int          rdelay;
    } item_t;

    item_t exp_q[$];

    logic [31:0] m_acc = '0;
    logic        m_zero = 1'b1;
    logic        m_neg = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] m, input logic [1:0] l, input logic [31:0] op);
        case (m)
            2'd0:    return op[31:28];
            2'd1:    return 4'b0001 << l;
            2'd2:    return l[0] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // Slave model and monitor: pops the expected item on acceptance.
    int          wait_cnt = 0;
    bit          rd_pending = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_value = '0;

    initial begin
        forever begin
            @(negedge clk);
            avm_readdatavalid_i = 1'b0;
            if (rd_pending) begin
                if (rd_cnt == 0) begin
                    avm_readdatavalid_i = 1'b1;
                    avm_readdata_i = rd_value;
                    rd_pending = 0;
                end else begin
                    rd_cnt--;
                end
            end
            if (avm_read_o || avm_write_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected request", avm_address_o, 32'h0);
                    avm_waitrequest_i = 1'b0;
                end else begin
                    item_t it;
                    it = exp_q[0];
                    // R8: every stalled cycle and the accepted one present the same request
                    chk(avm_write_o == it.wr && avm_read_o == !it.wr, "R8 strobe",
                        {30'd0, avm_write_o, avm_read_o}, {30'd0, it.wr, !it.wr});
                    chk(avm_address_o == it.addr, "R1 address", avm_address_o, it.addr);
                    chk(avm_byteenable_o == it.be, "R2-R5 byteenable",
                        {28'd0, avm_byteenable_o}, {28'd0, it.be});
                    if (it.wr)
                        chk(avm_writedata_o == it.wdata, "R7 writedata", avm_writedata_o, it.wdata);
                    if (wait_cnt < it.waits) begin
                        avm_waitrequest_i = 1'b1;
                        wait_cnt++;
                    end else begin
                        avm_waitrequest_i = 1'b0;
                        wait_cnt = 0;
                        void'(exp_q.pop_front());
                        if (!it.wr) begin
                            rd_pending = 1;
                            rd_cnt = it.rdelay;
                            rd_value = it.rdata;
                        end
                    end
                end
            end else begin
                avm_waitrequest_i = 1'b0;
            end
        end
    end

    // Driver: pushes the expected transfer, starts it, checks timing and result.
    task automatic run_op(input logic wr, input logic [1:0] mode, input logic [1:0] lane,
                          input logic [31:0] idx, input logic [31:0] op, input logic [31:0] acc,
                          input logic [31:0] rdata, input int waits, input int rdelay,
                          input bit extra);
        item_t it;
        int got = 0;
        int want;
        it.wr = wr;
        it.addr = idx + {4'd0, op[27:0]};
        it.be = exp_be(mode, lane, op);
        it.wdata = acc;
        it.rdata = rdata;
        it.waits = waits;
        it.rdelay = rdelay;
        exp_q.push_back(it);
        want = 4 + waits + (wr ? 0 : rdelay);

        @(negedge clk);
        start_i = 1'b1;
        is_write_i = wr;
        lane_mode_i = mode;
        lane_sel_i = lane;
        index_i = idx;
        operand_i = op;
        acc_i = acc;
        for (int n = 1; n <= 80; n++) begin
            @(negedge clk);
            if (extra && n < 4) begin
                // R11/R7: busy-time start with different inputs must be ignored
                start_i = 1'b1;
                is_write_i = ~wr;
                index_i = ~idx;
                operand_i = ~op;
                acc_i = ~acc;
                lane_mode_i = ~mode;
            end else begin
                start_i = 1'b0;
            end
            if (done_o) begin
                got = n;
                break;
            end
        end
        chk(got == want, "R9 done latency", got, want);
        if (!wr) begin
            m_acc = rdata;
            m_zero = (rdata == 0);
            m_neg = rdata[31];
        end
        chk(acc_o == m_acc, "R6 acc", acc_o, m_acc);
        chk(zero_o == m_zero && neg_o == m_neg, "R6 flags",
            {30'd0, zero_o, neg_o}, {30'd0, m_zero, m_neg});
        if (extra) start_i = 1'b1;   // start during the done cycle
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            chk(!done_o, "R10 single done", {31'd0, done_o}, 32'd0);
        end
        chk(exp_q.size() == 0, "R11 queue drained", exp_q.size(), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!avm_read_o && !avm_write_o && !done_o, "R12 strobes/done",
            {29'd0, avm_read_o, avm_write_o, done_o}, 32'd0);
        chk(acc_o == 0 && zero_o && !neg_o, "R12 acc/flags",
            {acc_o[29:0], zero_o, neg_o}, 32'h2);

        // R5 word read of a negative value, no stalls
        run_op(1'b0, 2'd3, 2'd0, 32'h0000_1000, 32'h0000_0010, 32'h0, 32'h8000_0004, 0, 0, 0);
        // R3 every byte lane, zero read data
        for (int l = 0; l < 4; l++)
            run_op(1'b0, 2'd1, 2'(l), 32'h0000_0200 + 32'(l), 32'h0000_0004, 32'h0, 32'h0, 0, 0, 0);
        // R6 write leaves flags from prior zero read; R4 lower and upper halves
        run_op(1'b1, 2'd2, 2'd0, 32'h0000_3000, 32'h0000_0002, 32'hDEAD_BEEF, 32'h0, 2, 0, 0);
        run_op(1'b1, 2'd2, 2'd2, 32'h0000_3000, 32'h0000_0002, 32'h1234_5678, 32'h0, 0, 0, 0);
        run_op(1'b1, 2'd2, 2'd1, 32'h0000_3000, 32'h0000_0000, 32'h0BAD_F00D, 32'h0, 1, 0, 0);
        // R2 raw nibble, R1 top nibble excluded from address
        run_op(1'b1, 2'd0, 2'd3, 32'h0100_0000, 32'hA123_4567, 32'h5555_AAAA, 32'h0, 0, 0, 0);
        run_op(1'b0, 2'd0, 2'd0, 32'h0000_0040, 32'h0FFF_FFFF, 32'h0, 32'h7FFF_FFFF, 0, 1, 0);
        // R1 wrap modulo 2^32 with operand top nibble all ones
        run_op(1'b0, 2'd3, 2'd0, 32'hFFFF_FFF0, 32'hF000_0020, 32'h0, 32'h0000_0001, 1, 0, 0);
        // R8/R10/R11 stalls, delayed data, busy starts with changed inputs
        run_op(1'b0, 2'd1, 2'd2, 32'h0000_8000, 32'h0000_0100, 32'h0, 32'hFFFF_FFFF, 3, 2, 1);
        run_op(1'b1, 2'd3, 2'd0, 32'h0000_9000, 32'h0000_0008, 32'hCAFE_0001, 32'h0, 2, 0, 1);
        run_op(1'b0, 2'd2, 2'd1, 32'h0000_A000, 32'h0000_0000, 32'h0, 32'h0, 0, 3, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule